// File: doc/BRIEF.md
# Ethernet PHY Status LED Controller

This block turns the live status signals of an Ethernet PHY into three active-high LED enables: a link lamp, a speed lamp and a shared activity/collision lamp. A 2-bit mode input picks one of three mappings. The low bit of the mode overrides the high bit, so only three of the four codes are distinct.

Single-cycle activity and collision pulses are too short to see. An internal tick prescaler is used to hold each pulse for a programmable number of ticks, so the lamp stays lit. In the two modes where the link lamp reports traffic, the link lamp blinks at a fixed half-period while stretched activity is present. It stays solid on when there is no activity. A bypass input turns off stretching, and the lamps then follow the raw pulse inputs directly.

Top module: `led_status_ctrl`

## Requirements
- R1: Mode decode. When `cfg_mode[0]` is 1, mode A applies whatever `cfg_mode[1]` holds. `cfg_mode` = 2'b00 selects mode B and 2'b10 selects mode C.
- R2: In every mode, `led_speed` is 1 when `speed_100` is 1 and 0 when it is 0.
- R3: While `link_ok` is 0, `led_link` is 0 in every mode, even during activity.
- R4: In mode A, `led_link` equals `link_ok` and never blinks on activity.
- R5: In mode A, `led_actcol` shows stretched activity, and collision pulses have no effect on it.
- R6: In mode B, `led_actcol` shows stretched collision, and activity pulses have no effect on it.
- R7: In mode C, `led_actcol` equals `full_duplex`, with 1 meaning full duplex.
- R8: With stretching on, a pulse lights its lamp from the next clock. The lamp stays lit for at least (STRETCH_TICKS-1)*CLK_PER_TICK and at most STRETCH_TICKS*CLK_PER_TICK clocks after the last pulse.
- R9: With `cfg_no_stretch` at 1, `led_actcol` follows the raw `act_pulse` (mode A) or `col_pulse` (mode B) in the same cycle, with no hold.
- R10: In modes B and C with link good, stretched activity makes `led_link` alternate. The first half-period is lit, and each later half-period lasts exactly BLINK_TICKS*CLK_PER_TICK clocks. Without activity the lamp is solid on.
- R11: After reset, with no pulses applied, `led_actcol` is 0 in modes A and B and `led_link` equals `link_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | LED mapping mode select |
| cfg_no_stretch | input | 1 | 1 = bypass pulse stretching |
| link_ok | input | 1 | Link good |
| speed_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| act_pulse | input | 1 | Activity event pulse |
| col_pulse | input | 1 | Collision event pulse |
| full_duplex | input | 1 | 1 = full duplex |
| led_link | output | 1 | Link lamp enable |
| led_speed | output | 1 | Speed lamp enable |
| led_actcol | output | 1 | Activity/collision lamp enable |

## Verification
The assertions check four things on every cycle:
- a dark link lamp whenever the link is down;
- the reload and the downward-only count of the stretch timers;
- that the blink phase changes only on a tick;
- that a falling link lamp under a steady good link is always explained by activity in a blinking mode.

The exact lit duration of a stretched pulse and the length of a blink half-period depend on the tick phase and on the history of the inputs. These, the full mode decode and the bypass path are shown by the bench's sweeps and timed scenarios.

// File: rtl/led_status_ctrl.sv
module led_status_ctrl #(
  parameter int CLK_PER_TICK  = 25000,
  parameter int STRETCH_TICKS = 50,
  parameter int BLINK_TICKS   = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_no_stretch,
  input  logic       link_ok,
  input  logic       speed_100,
  input  logic       act_pulse,
  input  logic       col_pulse,
  input  logic       full_duplex,
  output logic       led_link,
  output logic       led_speed,
  output logic       led_actcol
);
  localparam int PW = (CLK_PER_TICK  < 2) ? 1 : $clog2(CLK_PER_TICK);
  localparam int SW = $clog2(STRETCH_TICKS + 1);
  localparam int BW = (BLINK_TICKS   < 2) ? 1 : $clog2(BLINK_TICKS);

  logic [PW-1:0] pre;
  logic [SW-1:0] act_left, col_left;
  logic [BW-1:0] blink_cnt;
  logic          dark;
  logic          tick, act_eff, col_eff, mode_a, mode_b;

  assign tick = (pre == PW'(CLK_PER_TICK - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_left <= '0;
      col_left <= '0;
    end else begin
      if (act_pulse)                   act_left <= SW'(STRETCH_TICKS);
      else if (tick && act_left != '0) act_left <= act_left - 1'b1;
      if (col_pulse)                   col_left <= SW'(STRETCH_TICKS);
      else if (tick && col_left != '0) col_left <= col_left - 1'b1;
    end
  end

  assign act_eff = cfg_no_stretch ? act_pulse : (act_left != '0);
  assign col_eff = cfg_no_stretch ? col_pulse : (col_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !act_eff) begin
      blink_cnt <= '0;
      dark      <= 1'b0;
    end else if (tick) begin
      if (blink_cnt == BW'(BLINK_TICKS - 1)) begin
        blink_cnt <= '0;
        dark      <= ~dark;
      end else begin
        blink_cnt <= blink_cnt + 1'b1;
      end
    end
  end

  assign mode_a     = cfg_mode[0];
  assign mode_b     = (cfg_mode == 2'b00);
  assign led_speed  = speed_100;
  assign led_link   = link_ok & ~(~mode_a & act_eff & dark);
  assign led_actcol = mode_a ? act_eff : (mode_b ? col_eff : full_duplex);

  AST_LINK_DOWN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |-> !led_link); // R3

  AST_STRETCH_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |=> (act_left == SW'(STRETCH_TICKS))); // R8

  AST_STRETCH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_pulse && act_left != '0) |=> (act_left <= $past(act_left))); // R8

  AST_BLINK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_eff && $past(act_eff) && dark != $past(dark)) |-> $past(tick)); // R10

  AST_FALL_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ok && $past(link_ok) && $fell(led_link)) |-> (!cfg_mode[0] && act_eff)); // R4
endmodule

// File: tb/led_status_ctrl_test.sv
module led_status_ctrl_test;
  localparam int C = 4;
  localparam int S = 3;
  localparam int B = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b01;
  logic cfg_no_stretch = 1'b0;
  logic link_ok = 1'b0, speed_100 = 1'b0, act_pulse = 1'b0, col_pulse = 1'b0, full_duplex = 1'b0;
  logic led_link, led_speed, led_actcol;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  led_status_ctrl #(.CLK_PER_TICK(C), .STRETCH_TICKS(S), .BLINK_TICKS(B)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_no_stretch(cfg_no_stretch),
    .link_ok(link_ok), .speed_100(speed_100), .act_pulse(act_pulse), .col_pulse(col_pulse),
    .full_duplex(full_duplex), .led_link(led_link), .led_speed(led_speed), .led_actcol(led_actcol));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_act();
    @(negedge clk); act_pulse = 1'b1;
    @(negedge clk); act_pulse = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lit, offc, onc, run, first;
    idle(4);
    @(negedge clk); rst_n = 1'b1; link_ok = 1'b1;
    #1;
    chk("R11 actcol after reset", led_actcol, 0);
    chk("R11 link after reset", led_link, 1);

    // R1 R2 R3 R7 sweep of static inputs over every mode code
    for (int m = 0; m < 4; m++)
      for (int v = 0; v < 8; v++) begin
        @(negedge clk);
        cfg_mode = 2'(m); link_ok = v[0]; speed_100 = v[1]; full_duplex = v[2];
        #1;
        chk("R3 link static", led_link, v[0]);
        chk("R2 speed", led_speed, v[1]);
        chk("R1 R7 actcol static", led_actcol, (m == 2) ? v[2] : 0);
      end

    // R8 R5 stretch length in mode A (code 11 also decodes as mode A)
    @(negedge clk); cfg_mode = 2'b11; link_ok = 1'b1; full_duplex = 1'b1;
    pulse_act();
    #1;
    chk("R8 lit next cycle", led_actcol, 1);
    lit = 1;
    for (int i = 0; i < 20; i++) begin step(); if (led_actcol) lit++; end
    chk("R8 hold at least", int'(lit >= (S - 1) * C), 1);
    chk("R8 hold at most", int'(lit <= S * C), 1);

    // R5 collision ignored in mode A
    @(negedge clk); col_pulse = 1'b1;
    @(negedge clk); col_pulse = 1'b0; #1;
    chk("R5 collision ignored", led_actcol, 0);
    idle(16);

    // R6 collision shown in mode B, activity ignored
    @(negedge clk); cfg_mode = 2'b00;
    pulse_act(); #1;
    chk("R6 activity ignored", led_actcol, 0);
    idle(16);
    @(negedge clk); col_pulse = 1'b1;
    @(negedge clk); col_pulse = 1'b0; #1;
    chk("R6 collision lit", led_actcol, 1);
    idle(16);
    chk("R6 collision expired", led_actcol, 0);

    // R9 bypass follows raw pulses
    @(negedge clk); cfg_no_stretch = 1'b1; cfg_mode = 2'b01; act_pulse = 1'b1; #1;
    chk("R9 raw act high", led_actcol, 1);
    @(negedge clk); act_pulse = 1'b0; #1;
    chk("R9 raw act low", led_actcol, 0);
    step();
    chk("R9 no hold", led_actcol, 0);
    @(negedge clk); cfg_mode = 2'b00; col_pulse = 1'b1; #1;
    chk("R9 raw col high", led_actcol, 1);
    @(negedge clk); col_pulse = 1'b0; #1;
    chk("R9 raw col low", led_actcol, 0);
    @(negedge clk); cfg_no_stretch = 1'b0;
    idle(16);

    // R10 blinking in mode C under continuous activity
    @(negedge clk); cfg_mode = 2'b10; act_pulse = 1'b1;
    step();
    chk("R10 first half lit", led_link, 1);
    offc = 0; onc = 0; run = 0; first = -1;
    for (int i = 0; i < 60; i++) begin
      step();
      if (!led_link) begin offc++; run++; end
      else begin
        onc++;
        if (run > 0 && first < 0) first = run;
        run = 0;
      end
    end
    chk("R10 blinks off", int'(offc > 0), 1);
    chk("R10 blinks on", int'(onc > 0), 1);
    chk("R10 half period", first, B * C);
    @(negedge clk); act_pulse = 1'b0;
    idle(20);
    chk("R10 solid after idle", led_link, 1);

    // R4 no blink in mode A
    @(negedge clk); cfg_mode = 2'b01; act_pulse = 1'b1;
    offc = 0;
    for (int i = 0; i < 40; i++) begin step(); if (!led_link) offc++; end
    chk("R4 solid link mode A", offc, 0);

    // R3 link down under activity in mode B
    @(negedge clk); cfg_mode = 2'b00; link_ok = 1'b0;
    onc = 0;
    for (int i = 0; i < 40; i++) begin step(); if (led_link) onc++; end
    chk("R3 dark with link down", onc, 0);
    @(negedge clk); act_pulse = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule